// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is an 18-bit first-in first-out buffer whose write and read ports are clocked independently. The two clocks may be the same net or may be unrelated. A word is stored on each write-clock edge while the write enable is high, and the oldest word is moved into a registered output on each read-clock edge while the read enable is high. Write and read pointers cross between the domains as gray code through two-flop synchronizers.

Five status flags are produced. Empty and almost-empty come from the read domain. Full, almost-full and half-full come from the write domain. The two "almost" thresholds are offsets held in the block. Reset sets them to a default, and the user can change or read them back through the load input. While load is high, the data ports stop carrying FIFO traffic. Instead they step through the two offsets in a fixed order. An output enable gates the read data to zero and drops an output-valid indication. This takes the place of a tri-state bus.

Top module: `dual_clk_fifo`

## Requirements
- R1: With load low and the FIFO not full, each write-clock edge with write enable high stores the input word. Words leave the FIFO in the order they were written.
- R2: With load low and the FIFO not empty, each read-clock edge with read enable high places the oldest stored word on the data output. The output register holds its value at all other edges.
- R3: The empty flag is high when the read domain sees no stored words. The full flag is high when the write domain sees DEPTH stored words. After the opposite side has moved, each flag updates within three clock edges of its own domain.
- R4: A write while full and a read while empty are both ignored. No word is lost, none is duplicated, and the data output does not change.
- R5: Almost-empty is high when the read-domain fill count is less than or equal to the almost-empty offset.
- R6: Almost-full is high when the write-domain free space (DEPTH minus fill count) is less than or equal to the almost-full offset.
- R7: Half-full is high when the write-domain fill count is greater than DEPTH/2.
- R8: While load is high, write-enabled write-clock edges write offsets in the order almost-empty, almost-full, then almost-empty again, and so on. Each offset takes the low bits of the data input. While load is high, read-enabled read-clock edges place the offsets on the data output in the same order, zero-extended. Each sequence starts at the almost-empty offset whenever load was low at the previous edge of its clock. During load, FIFO pointers and contents are untouched.
- R9: An asynchronous active-low reset empties the FIFO and sets empty=1, almost-empty=1, full=0, almost-full=0, half-full=0 and data output 0. It also restores both offsets to DEPTH/32.
- R10: With output enable low, the data output is 0 and output-valid is 0. With it high, output-valid is 1 and the data output shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wen_i | input | 1 | Write enable |
| din_i | input | 18 | Write data, or offset value while load is high |
| ren_i | input | 1 | Read enable |
| oe_i | input | 1 | Output enable for the read data |
| ld_i | input | 1 | Offset load/readback select |
| dout_o | output | 18 | Registered read data, gated by output enable |
| dout_vld_o | output | 1 | Output enable is active |
| empty_o | output | 1 | No words stored (read domain) |
| full_o | output | 1 | DEPTH words stored (write domain) |
| aempty_o | output | 1 | Fill count at or below the almost-empty offset |
| afull_o | output | 1 | Free space at or below the almost-full offset |
| half_o | output | 1 | Fill count above DEPTH/2 |

## Verification
The assertions assume three things about the inputs. Offsets are reprogrammed only while the FIFO is idle, because the almost-empty offset is held in the write domain and read quasi-statically by the read domain. The load input changes only while the opposite port is inactive. Reset is released cleanly in both domains. The stimulus follows these rules by running both ports from one shared clock. It changes every input on the falling edge, and it toggles load or programs offsets only when the buffer is drained and neither enable is active. Under these conditions every flag latency is a fixed number of edges, so the expected values are exact.

// File: rtl/dual_clk_fifo_pkg.sv
package dual_clk_fifo_pkg;

  typedef enum logic {SEL_AE = 1'b0, SEL_AF = 1'b1} off_sel_e;

  // gray to binary, fixed 16-bit span; callers zero-extend narrower codes
  function automatic logic [15:0] gray2bin(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dual_clk_fifo_sync.sv
module dual_clk_fifo_sync #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/dual_clk_fifo_wr.sv
module dual_clk_fifo_wr
  import dual_clk_fifo_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wen_i,
  input  logic                      ld_i,
  input  logic [$clog2(DEPTH):0]    off_din_i,
  input  logic [$clog2(DEPTH):0]    rgray_s_i,
  output logic                      mem_we_o,
  output logic [$clog2(DEPTH)-1:0]  mem_addr_o,
  output logic [$clog2(DEPTH):0]    wgray_o,
  output logic [$clog2(DEPTH):0]    ae_off_o,
  output logic [$clog2(DEPTH):0]    af_off_o,
  output logic                      full_o,
  output logic                      afull_o,
  output logic                      half_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEF_OFF = CW'(DEPTH / 32);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] wbin_q, wbin_nxt, rbin_s, wcount, wfree;
  logic          push;
  off_sel_e      sel_q;

  assign rbin_s   = CW'(gray2bin(16'(rgray_s_i)));
  assign wcount   = wbin_q - rbin_s;
  assign wfree    = FULL_CNT - wcount;
  assign full_o   = (wcount == FULL_CNT);
  assign afull_o  = (wfree <= af_off_o);
  assign half_o   = (wcount > HALF_CNT);
  assign push     = wen_i & ~ld_i & ~full_o;
  assign wbin_nxt = wbin_q + CW'(push);
  assign mem_we_o = push;
  assign mem_addr_o = wbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_o <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  // offset sequencer: restarts at almost-empty whenever load is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= SEL_AE;
      ae_off_o <= DEF_OFF;
      af_off_o <= DEF_OFF;
    end else if (!ld_i) begin
      sel_q <= SEL_AE;
    end else if (wen_i) begin
      if (sel_q == SEL_AE) begin
        ae_off_o <= off_din_i;
        sel_q    <= SEL_AF;
      end else begin
        af_off_o <= off_din_i;
        sel_q    <= SEL_AE;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wen_i && !ld_i) |=> $stable(wbin_q)); // R4
  AST_WCOUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcount <= FULL_CNT); // R3
  AST_FULL_AFULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> afull_o); // R6
  AST_FULL_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o); // R7
  AST_LD_WPTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> $stable(wbin_q)); // R8
endmodule

// File: rtl/dual_clk_fifo_rd.sv
module dual_clk_fifo_rd
  import dual_clk_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 18
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ren_i,
  input  logic                      ld_i,
  input  logic [$clog2(DEPTH):0]    wgray_s_i,
  input  logic [DW-1:0]             mem_rdata_i,
  input  logic [$clog2(DEPTH):0]    ae_off_i,
  input  logic [$clog2(DEPTH):0]    af_off_i,
  output logic [$clog2(DEPTH)-1:0]  mem_addr_o,
  output logic [$clog2(DEPTH):0]    rgray_o,
  output logic [DW-1:0]             rdata_o,
  output logic                      empty_o,
  output logic                      aempty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [CW-1:0] rbin_q, rbin_nxt, wbin_s, rcount;
  logic          pop;
  off_sel_e      sel_q;

  assign wbin_s     = CW'(gray2bin(16'(wgray_s_i)));
  assign rcount     = wbin_s - rbin_q;
  assign empty_o    = (rcount == '0);
  assign aempty_o   = (rcount <= ae_off_i);
  assign pop        = ren_i & ~ld_i & ~empty_o;
  assign rbin_nxt   = rbin_q + CW'(pop);
  assign mem_addr_o = rbin_q[AW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_o <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      sel_q   <= SEL_AE;
    end else if (!ld_i) begin
      sel_q <= SEL_AE;
      if (pop) rdata_o <= mem_rdata_i;
    end else if (ren_i) begin
      rdata_o <= {{(DW-CW){1'b0}}, (sel_q == SEL_AE) ? ae_off_i : af_off_i};
      sel_q   <= (sel_q == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && ren_i && !ld_i) |=> ($stable(rbin_q) && $stable(rdata_o))); // R4
  AST_RCOUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcount <= CW'(DEPTH)); // R3
  AST_EMPTY_AEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o); // R5
  AST_LD_RPTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> $stable(rbin_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ren_i |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 18
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic [DW-1:0] din_i,
  input  logic          ren_i,
  input  logic          oe_i,
  input  logic          ld_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_vld_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          aempty_o,
  output logic          afull_o,
  output logic          half_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_rdata, rdata;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] wgray, rgray, wgray_s, rgray_s, ae_off, af_off;
  logic          mem_we;

  dual_clk_fifo_wr #(.DEPTH(DEPTH)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_i(wen_i), .ld_i(ld_i),
    .off_din_i(din_i[CW-1:0]), .rgray_s_i(rgray_s),
    .mem_we_o(mem_we), .mem_addr_o(waddr), .wgray_o(wgray),
    .ae_off_o(ae_off), .af_off_o(af_off),
    .full_o(full_o), .afull_o(afull_o), .half_o(half_o)
  );

  dual_clk_fifo_rd #(.DEPTH(DEPTH), .DW(DW)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .ren_i(ren_i), .ld_i(ld_i),
    .wgray_s_i(wgray_s), .mem_rdata_i(mem_rdata),
    .ae_off_i(ae_off), .af_off_i(af_off),
    .mem_addr_o(raddr), .rgray_o(rgray), .rdata_o(rdata),
    .empty_o(empty_o), .aempty_o(aempty_o)
  );

  dual_clk_fifo_sync #(.W(CW)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s)
  );

  dual_clk_fifo_sync #(.W(CW)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s)
  );

  always_ff @(posedge wclk_i) begin
    if (mem_we) mem[waddr] <= din_i;
  end
  assign mem_rdata = mem[raddr];

  // stands in for a tri-state output
  assign dout_o     = oe_i ? rdata : '0;
  assign dout_vld_o = oe_i;

  AST_NO_DUAL_FLAG: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> !aempty_o || !empty_o); // R3
endmodule

// File: tb/dual_clk_fifo_bench.sv
`timescale 1ns/1ps
module dual_clk_fifo_bench;
  localparam int DEPTH = 256;
  localparam int NV = 9;
  localparam logic [17:0] VEC_D  [NV] = '{18'h00001, 18'h3FFFF, 18'h15555, 18'h2AAAA,
                                          18'h0F0F0, 18'h30303, 18'h12345, 18'h00000, 18'h2BEEF};
  localparam logic        VEC_AE [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  logic clk = 0, rst_n = 0, wen = 0, ren = 0, oe = 1, ld = 0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic dout_vld, empty, full, aempty, afull, half;
  int total = 0, bad = 0;
  logic [17:0] saved;

  always #2.5 clk = ~clk;

  dual_clk_fifo #(.DEPTH(DEPTH)) u_dual_clk_fifo (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .wen_i(wen), .din_i(din),
    .ren_i(ren), .oe_i(oe), .ld_i(ld), .dout_o(dout), .dout_vld_o(dout_vld),
    .empty_o(empty), .full_o(full), .aempty_o(aempty), .afull_o(afull), .half_o(half)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [17:0] d);
    wen = 1; din = d;
    @(negedge clk);
    wen = 0;
  endtask

  task automatic pop_chk(input logic [17:0] exp, input string req);
    ren = 1;
    @(negedge clk);
    ren = 0;
    chk(req, 32'(dout), 32'(exp));
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    report();
  end

  initial begin
    idle(3);
    // R9 reset state
    chk("R9 empty", 32'(empty), 1);
    chk("R9 aempty", 32'(aempty), 1);
    chk("R9 full", 32'(full), 0);
    chk("R9 afull", 32'(afull), 0);
    chk("R9 half", 32'(half), 0);
    chk("R9 dout", 32'(dout), 0);
    rst_n = 1;
    idle(2);

    // R1 R5 vector walk: almost-empty vs default offset 8
    for (int i = 0; i < NV; i++) begin
      push(VEC_D[i]);
      idle(3);
      chk("R3 empty low", 32'(empty), 0);
      chk("R5 aempty", 32'(aempty), 32'(VEC_AE[i]));
    end
    for (int i = 0; i < NV; i++) pop_chk(VEC_D[i], "R1 R2 order");
    chk("R3 empty after drain", 32'(empty), 1);

    // R4 read while empty
    saved = dout;
    ren = 1; @(negedge clk); ren = 0;
    chk("R4 dout hold on empty read", 32'(dout), 32'(saved));
    push(18'h00155);
    idle(3);
    pop_chk(18'h00155, "R4 no underflow");
    idle(4);

    // R6 R7 R3 fill
    for (int i = 0; i < DEPTH; i++) begin
      push(18'(i));
      if (i == 127) chk("R7 half at 128", 32'(half), 0);
      if (i == 128) chk("R7 half at 129", 32'(half), 1);
      if (i == 246) chk("R6 afull at 247", 32'(afull), 0);
      if (i == 247) chk("R6 afull at 248", 32'(afull), 1);
      if (i == 254) chk("R3 full at 255", 32'(full), 0);
    end
    chk("R3 full", 32'(full), 1);
    push(18'h3FFFF);  // R4 write while full
    idle(3);
    for (int i = 0; i < DEPTH; i++) pop_chk(18'(i), "R4 R1 full drain");
    chk("R4 empty after drain", 32'(empty), 1);
    idle(4);
    chk("R3 full cleared", 32'(full), 0);

    // R8 offset load and readback
    ld = 1; wen = 1;
    din = 18'd3;  @(negedge clk);
    din = 18'd10; @(negedge clk);
    din = 18'd6;  @(negedge clk);
    wen = 0; ld = 0;
    @(negedge clk);
    ld = 1; ren = 1;
    @(negedge clk); chk("R8 readback ae", 32'(dout), 6);
    @(negedge clk); chk("R8 readback af", 32'(dout), 10);
    @(negedge clk); chk("R8 readback wrap", 32'(dout), 6);
    ren = 0; ld = 0;
    idle(3);
    chk("R8 fifo untouched", 32'(empty), 1);

    // R5 with programmed offset 6
    for (int i = 0; i < 6; i++) push(18'(100 + i));
    idle(3);
    chk("R5 aempty at 6", 32'(aempty), 1);
    push(18'd106);
    idle(3);
    chk("R5 aempty at 7", 32'(aempty), 0);
    for (int i = 0; i < 7; i++) pop_chk(18'(100 + i), "R2 after load");

    // R10 output enable
    oe = 0; #1;
    chk("R10 dout gated", 32'(dout), 0);
    chk("R10 vld low", 32'(dout_vld), 0);
    oe = 1; #1;
    chk("R10 dout restored", 32'(dout), 106);
    chk("R10 vld high", 32'(dout_vld), 1);
    idle(4);

    // R9 reset mid-run restores defaults
    push(18'd1); push(18'd2); push(18'd3);
    rst_n = 0;
    idle(1);
    chk("R9 empty on reset", 32'(empty), 1);
    chk("R9 dout on reset", 32'(dout), 0);
    rst_n = 1;
    idle(2);
    for (int i = 0; i < 8; i++) push(18'(200 + i));
    idle(3);
    chk("R9 default ae at 8", 32'(aempty), 1);
    push(18'd208);
    idle(3);
    chk("R9 default ae at 9", 32'(aempty), 0);
    pop_chk(18'd200, "R9 fresh order");

    report();
  end
endmodule